// File: doc/BRIEF.md
# Stereo Gain Soft-Step Ramp Controller

This block sets the gain code applied to a two-channel input amplifier, so that a new gain setting never reaches the amplifier in one jump. Each channel has a requested gain code and a requested mute. The block moves the applied code toward the request by at most one code per step event. One code is a 0.5 dB increment, and the code value is twice the gain in dB, from 0 (0 dB) up to 119 (59.5 dB). Step events are paced by the converter's output-sample strobe. A rate select chooses between a step on every strobe and a step on every second strobe.

Each channel ramps on its own. A channel can be switched off by itself, for example for mono recording. While it is off it keeps its applied state exactly as it was. Muting is gradual as well. A channel that is asked to mute first ramps down to code 0 and only then reports muted. A channel that is asked to unmute leaves mute at code 0 and then ramps up. A settled output tells the control side that every enabled channel has reached what was asked of it. All pins are plain control and status levels. There is no data stream, so no valid/ready handshake applies.

Top module: `gain_ramp`

## Requirements
- R1: While reset is asserted and after it is released, every channel reports applied mute = 1 with applied code 0, until its first step event.
- R2: The applied code of a channel changes by at most one per step event. A cycle without a sample strobe leaves every applied code and mute flag unchanged.
- R3: With `half_rate` = 0, every strobe seen by an enabled channel is a step event. With `half_rate` = 1, only every second strobe is a step event. The first step comes on the second strobe after reset or after the channel is re-enabled.
- R4: A requested code above 119 is treated as 119. The applied code never exceeds 119.
- R5: When a muted channel's mute request is 0, its next step event clears the applied mute and leaves the code at 0. The events after that raise the code by one each, up to the target.
- R6: When an unmuted channel's mute request is 1, its step events lower the code by one down to 0. The next step event after the code reaches 0 sets the applied mute.
- R7: If the target changes during a ramp, the next step event moves toward the new target. The step pacing is not restarted.
- R8: The two channels step independently, each toward its own target and mute request.
- R9: While `ch_en[c]` = 0, channel c holds its applied code and mute flag, and its every-second-strobe phase is cleared.
- R10: `settled` is 1 exactly when every enabled channel meets one of two conditions. Either its mute request is 1 and its applied mute is 1, or its mute request is 0, its applied mute is 0 and its applied code equals the clamped target. Disabled channels are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_stb | input | 1 | One-cycle pulse per converter output sample |
| half_rate | input | 1 | 0: step on every strobe, 1: step on every second strobe |
| ch_en | input | NCH | Per-channel enable |
| tgt_code | input | NCH x CODE_W | Requested gain code per channel (2 x dB) |
| tgt_mute | input | NCH | Requested mute per channel |
| app_code | output | NCH x CODE_W | Applied gain code per channel |
| app_mute | output | NCH | Applied mute per channel |
| settled | output | 1 | All enabled channels have reached their request |

## Verification
Applied codes and mute flags are registered. They change on the rising edge that samples a strobe and are checked at the falling edge that follows. The bench raises each strobe for one cycle and then waits a full cycle before it reads. `settled` is combinational from the registered state and the live request pins, so after a request change it is read after a short settling delay within the same low phase. To check the every-second-strobe pacing, the bench counts strobes from a known phase, set by a disable and re-enable, and expects movement only on the even strobes.

// File: rtl/gain_ramp_pkg.sv
package gain_ramp_pkg;
  localparam int unsigned DEF_NCH      = 2;
  localparam int unsigned DEF_CODE_W   = 7;
  localparam int unsigned DEF_CODE_MAX = 119;

  // Action a lane takes on its next step event.
  typedef enum logic [2:0] {
    MV_HOLD,
    MV_UP,
    MV_DOWN,
    MV_UNMUTE,
    MV_MUTE
  } move_e;
endpackage

// File: rtl/gain_ramp_pacer.sv
module gain_ramp_pacer (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_stb,
  input  logic half_rate,
  input  logic enable,
  output logic fire
);
  logic phase_q;

  assign fire = enable && sample_stb && (!half_rate || phase_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
    end else if (!enable) begin
      phase_q <= 1'b0;
    end else if (sample_stb) begin
      phase_q <= ~phase_q;
    end
  end
endmodule

// File: rtl/gain_ramp_stepper.sv
module gain_ramp_stepper
  import gain_ramp_pkg::*;
#(
  parameter int unsigned CODE_W   = DEF_CODE_W,
  parameter int unsigned CODE_MAX = DEF_CODE_MAX
) (
  input  logic [CODE_W-1:0] cur_code,
  input  logic              cur_muted,
  input  logic [CODE_W-1:0] req_code,
  input  logic              req_mute,
  output move_e             move,
  output logic              at_goal
);
  localparam logic [CODE_W-1:0] LIMIT = CODE_W'(CODE_MAX);

  logic [CODE_W-1:0] clamped;
  logic [CODE_W-1:0] goal;

  assign clamped = (req_code > LIMIT) ? LIMIT : req_code;
  assign goal    = req_mute ? '0 : clamped;

  always_comb begin
    move = MV_HOLD;
    if (cur_muted) begin
      if (!req_mute) move = MV_UNMUTE;
    end else if (cur_code < goal) begin
      move = MV_UP;
    end else if (cur_code > goal) begin
      move = MV_DOWN;
    end else if (req_mute) begin
      move = MV_MUTE;
    end
  end

  assign at_goal = (cur_muted == req_mute) && (cur_muted || (cur_code == clamped));
endmodule

// File: rtl/gain_ramp_lane.sv
module gain_ramp_lane
  import gain_ramp_pkg::*;
#(
  parameter int unsigned CODE_W   = DEF_CODE_W,
  parameter int unsigned CODE_MAX = DEF_CODE_MAX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_stb,
  input  logic              half_rate,
  input  logic              enable,
  input  logic [CODE_W-1:0] req_code,
  input  logic              req_mute,
  output logic [CODE_W-1:0] code_q,
  output logic              muted_q,
  output logic              at_goal
);
  logic  fire;
  move_e move;

  gain_ramp_pacer u_pacer (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_stb (sample_stb),
    .half_rate  (half_rate),
    .enable     (enable),
    .fire       (fire)
  );

  gain_ramp_stepper #(.CODE_W(CODE_W), .CODE_MAX(CODE_MAX)) u_step (
    .cur_code  (code_q),
    .cur_muted (muted_q),
    .req_code  (req_code),
    .req_mute  (req_mute),
    .move      (move),
    .at_goal   (at_goal)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q  <= '0;
      muted_q <= 1'b1;
    end else if (fire) begin
      case (move)
        MV_UP:     code_q  <= code_q + CODE_W'(1);
        MV_DOWN:   code_q  <= code_q - CODE_W'(1);
        MV_UNMUTE: muted_q <= 1'b0;
        MV_MUTE:   muted_q <= 1'b1;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/gain_ramp.sv
module gain_ramp
  import gain_ramp_pkg::*;
#(
  parameter int unsigned NCH      = DEF_NCH,
  parameter int unsigned CODE_W   = DEF_CODE_W,
  parameter int unsigned CODE_MAX = DEF_CODE_MAX
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sample_stb,
  input  logic                         half_rate,
  input  logic [NCH-1:0]               ch_en,
  input  logic [NCH-1:0][CODE_W-1:0]   tgt_code,
  input  logic [NCH-1:0]               tgt_mute,
  output logic [NCH-1:0][CODE_W-1:0]   app_code,
  output logic [NCH-1:0]               app_mute,
  output logic                         settled
);
  logic [NCH-1:0] lane_ok;

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    gain_ramp_lane #(.CODE_W(CODE_W), .CODE_MAX(CODE_MAX)) u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .sample_stb (sample_stb),
      .half_rate  (half_rate),
      .enable     (ch_en[c]),
      .req_code   (tgt_code[c]),
      .req_mute   (tgt_mute[c]),
      .code_q     (app_code[c]),
      .muted_q    (app_mute[c]),
      .at_goal    (lane_ok[c])
    );
  end

  assign settled = &(lane_ok | ~ch_en);
endmodule

// File: rtl/gain_ramp_chk.sv
module gain_ramp_chk #(
  parameter int unsigned NCH      = 2,
  parameter int unsigned CODE_W   = 7,
  parameter int unsigned CODE_MAX = 119
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       sample_stb,
  input logic [NCH-1:0]             ch_en,
  input logic [NCH-1:0]             tgt_mute,
  input logic [NCH-1:0][CODE_W-1:0] app_code,
  input logic [NCH-1:0]             app_mute,
  input logic                       settled
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    assert_step_small_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (app_code[c] == $past(app_code[c]) ||
                app_code[c] == $past(app_code[c]) + CODE_W'(1) ||
                app_code[c] == $past(app_code[c]) - CODE_W'(1)));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_stb |=> ($stable(app_code[c]) && $stable(app_mute[c])));

    assert_off_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en[c] |=> ($stable(app_code[c]) && $stable(app_mute[c])));

    assert_code_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      app_code[c] <= CODE_W'(CODE_MAX));

    assert_mute_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      app_mute[c] |-> app_code[c] == '0);

    assert_unmute_from_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(app_mute[c]) |-> (app_code[c] == '0 && !$past(tgt_mute[c])));

    assert_settled_mute_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (settled && ch_en[c] && tgt_mute[c]) |-> app_mute[c]);
  end
endmodule

bind gain_ramp gain_ramp_chk #(.NCH(NCH), .CODE_W(CODE_W), .CODE_MAX(CODE_MAX)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sample_stb (sample_stb),
  .ch_en      (ch_en),
  .tgt_mute   (tgt_mute),
  .app_code   (app_code),
  .app_mute   (app_mute),
  .settled    (settled)
);

// File: tb/gain_ramp_bench.sv
module gain_ramp_bench;
  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             sample_stb = 1'b0;
  logic             half_rate = 1'b0;
  logic [1:0]       ch_en = 2'b00;
  logic [1:0][6:0]  tgt_code = '0;
  logic [1:0]       tgt_mute = 2'b11;
  logic [1:0][6:0]  app_code;
  logic [1:0]       app_mute;
  logic             settled;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  gain_ramp u_gain_ramp (
    .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .half_rate(half_rate),
    .ch_en(ch_en), .tgt_code(tgt_code), .tgt_mute(tgt_mute),
    .app_code(app_code), .app_mute(app_mute), .settled(settled)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sample_stb = 1'b1;
      @(negedge clk); sample_stb = 1'b0;
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 mute0 in reset", app_mute[0], 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mute0", app_mute[0], 1);
    chk("R1 mute1", app_mute[1], 1);
    chk("R1 code0", app_code[0], 0);
    chk("R1 code1", app_code[1], 0);
    chk("R10 settled nothing enabled", settled, 1);
  endtask

  task automatic t_unmute_ramp;
    ch_en = 2'b01; tgt_mute[0] = 1'b0; tgt_code[0] = 7'd4;
    #1 chk("R10 not settled", settled, 0);
    pulse(1);
    chk("R5 unmute flag", app_mute[0], 0);
    chk("R5 unmute code", app_code[0], 0);
    pulse(1);
    chk("R5 first rise", app_code[0], 1);
    repeat (5) @(negedge clk);
    chk("R2 no strobe hold", app_code[0], 1);
    pulse(3);
    chk("R2 one per step", app_code[0], 4);
    pulse(2);
    chk("R2 hold at target", app_code[0], 4);
    chk("R10 settled", settled, 1);
    chk("R9 ch1 untouched", app_mute[1], 1);
  endtask

  task automatic t_half_rate;
    half_rate = 1'b1; tgt_code[0] = 7'd8; ch_en = 2'b00;
    pulse(1);
    chk("R9 disabled hold", app_code[0], 4);
    ch_en = 2'b01;
    pulse(1); chk("R3 strobe1 no step", app_code[0], 4);
    pulse(1); chk("R3 strobe2 step", app_code[0], 5);
    pulse(1); chk("R3 strobe3 no step", app_code[0], 5);
    pulse(1); chk("R3 strobe4 step", app_code[0], 6);
  endtask

  task automatic t_retarget;
    pulse(1); chk("R7 odd strobe", app_code[0], 6);
    tgt_code[0] = 7'd2;
    pulse(1); chk("R7 new direction no restart", app_code[0], 5);
    pulse(1); chk("R7 odd strobe after", app_code[0], 5);
    pulse(1); chk("R7 continues down", app_code[0], 4);
  endtask

  task automatic t_clamp;
    half_rate = 1'b0; tgt_code[0] = 7'd127;
    pulse(115);
    chk("R4 reach limit", app_code[0], 119);
    pulse(3);
    chk("R4 stay at limit", app_code[0], 119);
    chk("R4 R10 settled on clamp", settled, 1);
  endtask

  task automatic t_mute_down;
    tgt_mute[0] = 1'b1;
    pulse(119);
    chk("R6 code zero", app_code[0], 0);
    chk("R6 not yet muted", app_mute[0], 0);
    chk("R10 not settled yet", settled, 0);
    pulse(1);
    chk("R6 muted", app_mute[0], 1);
    chk("R10 settled muted", settled, 1);
  endtask

  task automatic t_independent;
    ch_en = 2'b11;
    tgt_mute = 2'b00; tgt_code[0] = 7'd3; tgt_code[1] = 7'd6;
    pulse(4);
    chk("R8 ch0 at target", app_code[0], 3);
    chk("R8 ch1 midway", app_code[1], 3);
    pulse(3);
    chk("R8 ch0 held", app_code[0], 3);
    chk("R8 ch1 at target", app_code[1], 6);
    chk("R10 both settled", settled, 1);
    ch_en = 2'b10; tgt_code[0] = 7'd10;
    #1 chk("R10 disabled ignored", settled, 1);
    pulse(1);
    chk("R9 ch0 held while off", app_code[0], 3);
  endtask

  initial begin
    t_reset();
    t_unmute_ramp();
    t_half_rate();
    t_retarget();
    t_clamp();
    t_mute_down();
    t_independent();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog requirement=all act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule